// File: doc/BRIEF.md
# Codec Control-Mode Start-Up Sequencer

This block brings a serial audio codec out of reset and programs it over a time-division serial link. After a `start` pulse it holds the codec's reset line low for a fixed number of system clocks. It then becomes master of the serial clock and the frame sync, and sends frames that carry two configuration words followed by zero words. The configuration words are built from the configuration inputs, which are captured when `start` is accepted. Every word the codec returns is captured and can be read back on `rx_words`.

Frames carry a handshake bit. The sequencer sends its bit as 0 and repeats frames until a returned frame shows the codec's bit as 0. It then sends its own bit as 1 for exactly a fixed number of further frames. After that it stops driving the clock and frame sync, raises the data-mode select and reports `done`. If the codec never clears its bit, a frame-count timeout raises `err` and returns the block to idle.

Top module: `codec_init_seq`

## Requirements
- R1: After reset the block is idle: `codec_rst_n`=0, `data_sel`=0, `link_drive`=0, `sclk_out`=0, `fs_out`=0, `sdout`=0, `done`=0, `err`=0, `rx_words`=0.
- R2: A `start` accepted while idle or done keeps `codec_rst_n` low for exactly RESET_CYCLES further clocks. `codec_rst_n` then goes high and the serial link starts on that same cycle. The default is 1,000,000 clocks, which is 25 ms at 40 MHz.
- R3: While the link runs, `sclk_out` has a period of CLK_DIV system clocks (default 16). Each bit period is low for its first CLK_DIV/2 clocks and high for the rest.
- R4: A frame is WORDS×16 bits (default 64). `fs_out` is high for exactly the first bit period of each frame. Words are sent first word first, each word MSB first.
- R5: The first transmitted word has these fields: bit 12 = `mic_boost_off`, bit 10 = the sequencer's handshake bit, bit 7 = `hpf_on`, bits 5:3 = `rate_code`, bit 2 = `stereo_on`, bits 1:0 = `fmt_code`. All other bits are 0.
- R6: The second transmitted word has these fields: bit 15 = `tri_immediate`, bit 13 = `alt_xtal`, bits 11:10 = `frame_code`, bit 9 = `codec_clk_master`, bit 8 = `codec_tx_mute`. All other bits are 0. Every further word is all zeros.
- R7: `sdout` changes only at the start of a bit period, while `sclk_out` is low. `sdin` is sampled on the cycle where `sclk_out` rises. At the end of each frame the whole received frame appears on `rx_words`, with the first received bit at the MSB, and it stays there until the next frame ends.
- R8: The sequencer's handshake bit is 0 until a frame ends whose received first word has bit 10 = 0. From the next frame on, the bit is 1.
- R9: After the handshake clears, exactly POST_FRAMES (default 4) more frames are sent. Then `link_drive`, `sclk_out`, `fs_out` and `sdout` go low, and `data_sel` and `codec_rst_n` stay high.
- R10: If TIMEOUT_FRAMES (default 1024) frames end during the handshake without a clear, `err` goes high and the block returns to idle, with `codec_rst_n` low. `err` clears on the next accepted `start`.
- R11: `done` is high from the handover until the next accepted `start`. A `start` while the sequence is running is ignored. Configuration changes after `start` do not affect the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the sequence when idle or done |
| mic_boost_off | input | 1 | First word bit 12 |
| hpf_on | input | 1 | First word bit 7 |
| rate_code | input | 3 | First word bits 5:3 |
| stereo_on | input | 1 | First word bit 2 |
| fmt_code | input | 2 | First word bits 1:0 |
| tri_immediate | input | 1 | Second word bit 15 |
| alt_xtal | input | 1 | Second word bit 13 |
| frame_code | input | 2 | Second word bits 11:10 |
| codec_clk_master | input | 1 | Second word bit 9 |
| codec_tx_mute | input | 1 | Second word bit 8 |
| sdin | input | 1 | Serial data from the codec |
| codec_rst_n | output | 1 | Codec reset, active low |
| data_sel | output | 1 | 0 = control mode, 1 = data mode |
| link_drive | output | 1 | Output enable for sclk_out and fs_out |
| sclk_out | output | 1 | Serial bit clock |
| fs_out | output | 1 | Frame sync |
| sdout | output | 1 | Serial data to the codec |
| rx_words | output | WORDS*16 | Last received frame |
| done | output | 1 | Handover complete |
| err | output | 1 | Handshake timeout |

## Verification
The codec model returns a handshake bit of 1 for a chosen number of frames, and the sequence is run with that number set to zero, one, two and more than the timeout. These runs separate a clear on the first frame, a clear after repeated frames, and a timeout, and each shows whether the tail count starts at the right frame. Each run uses a different configuration pattern, so a field placed in the wrong bit shows up in the serial stream. A mid-run `start` and configuration change shows whether the captured snapshot is used. The returned words change from frame to frame, so a received word that is stale or shifted is detected.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

  localparam int CW_W   = 16;
  localparam int HS_POS = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_HSK,
    ST_TAIL,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic       preamp_off;
    logic       hpf_en;
    logic [2:0] rate;
    logic       stereo;
    logic [1:0] fmt;
    logic       tri_now;
    logic       xtal2;
    logic [1:0] flen;
    logic       cmaster;
    logic       txoff;
  } codec_cfg_t;

  // First control word: converter setup plus the handshake bit
  function automatic logic [CW_W-1:0] ctrl_word_a(input codec_cfg_t c, input logic hs);
    logic [CW_W-1:0] w;
    w         = '0;
    w[12]     = c.preamp_off;
    w[HS_POS] = hs;
    w[7]      = c.hpf_en;
    w[5:3]    = c.rate;
    w[2]      = c.stereo;
    w[1:0]    = c.fmt;
    return w;
  endfunction

  // Second control word: link and clocking setup
  function automatic logic [CW_W-1:0] ctrl_word_b(input codec_cfg_t c);
    logic [CW_W-1:0] w;
    w       = '0;
    w[15]   = c.tri_now;
    w[13]   = c.xtal2;
    w[11:10] = c.flen;
    w[9]    = c.cmaster;
    w[8]    = c.txoff;
    return w;
  endfunction

endpackage

// File: rtl/codec_init_timer.sv
module codec_init_timer #(
  parameter int CLK_DIV    = 16,
  parameter int FRAME_BITS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  output logic                          sclk_o,
  output logic                          fs_o,
  output logic                          sample_o,
  output logic                          frame_end_o,
  output logic [$clog2(FRAME_BITS)-1:0] bit_idx_o
);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int HALF  = CLK_DIV / 2;

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;

  wire div_last = (div_q == DIV_W'(CLK_DIV - 1));
  wire bit_last = (bit_q == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
    end else if (!run) begin
      div_q <= '0;
      bit_q <= '0;
    end else begin
      div_q <= div_last ? '0 : div_q + 1'b1;
      if (div_last) bit_q <= bit_last ? '0 : bit_q + 1'b1;
    end
  end

  assign sclk_o      = run && (div_q >= DIV_W'(HALF));
  assign fs_o        = run && (bit_q == '0);
  assign sample_o    = run && (div_q == DIV_W'(HALF));
  assign frame_end_o = run && div_last && bit_last;
  assign bit_idx_o   = bit_q;

  // R4
  fs_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_o) |-> (run && bit_q == BIT_W'(1)));

  // R3
  sclk_rise_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(sclk_o)) |-> (div_q == DIV_W'(HALF)));

endmodule

// File: rtl/codec_init_serdes.sv
module codec_init_serdes
  import codec_init_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int WORDS      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic                          sample,
  input  logic                          frame_end,
  input  logic [$clog2(FRAME_BITS)-1:0] bit_idx,
  input  logic [FRAME_BITS-1:0]         tx_frame,
  input  logic                          sdin,
  output logic                          sdout,
  output logic                          hs_ret,
  output logic [FRAME_BITS-1:0]         rx_frame
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] rx_shift;

  assign sdout = run & tx_frame[TOP_IDX - bit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_shift <= '0;
    else if (sample) rx_shift <= {rx_shift[FRAME_BITS-2:0], sdin};
  end

  // Handshake bit of the returned first word, valid at frame end
  assign hs_ret = rx_shift[FRAME_BITS - CW_W + HS_POS];

  for (genvar g = 0; g < WORDS; g++) begin : g_rx_word
    logic [CW_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (frame_end) word_q <= rx_shift[g*CW_W +: CW_W];
    end
    assign rx_frame[g*CW_W +: CW_W] = word_q;
  end

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> $stable(rx_frame));

endmodule

// File: rtl/codec_init_ctrl.sv
module codec_init_ctrl
  import codec_init_pkg::*;
#(
  parameter int RESET_CYCLES   = 1000000,
  parameter int TIMEOUT_FRAMES = 1024,
  parameter int POST_FRAMES    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       frame_end,
  input  logic       hs_ret,
  input  codec_cfg_t cfg_in,
  output seq_state_t state,
  output codec_cfg_t cfg_q,
  output logic       hs_bit,
  output logic       err
);
  localparam int HOLD_W = $clog2(RESET_CYCLES + 1);
  localparam int FMAX   = (TIMEOUT_FRAMES > POST_FRAMES) ? TIMEOUT_FRAMES : POST_FRAMES;
  localparam int FC_W   = $clog2(FMAX + 1);

  logic [HOLD_W-1:0] hold_q;
  logic [FC_W-1:0]   fcnt_q;

  // Named events for the assertions
  wire accept_evt    = start && (state == ST_IDLE || state == ST_DONE);
  wire hold_last     = (hold_q == HOLD_W'(RESET_CYCLES - 1));
  wire hs_clear_evt  = (state == ST_HSK) && frame_end && !hs_ret;
  wire timeout_evt   = (state == ST_HSK) && frame_end && hs_ret &&
                       (fcnt_q == FC_W'(TIMEOUT_FRAMES - 1));
  wire tail_done_evt = (state == ST_TAIL) && frame_end &&
                       (fcnt_q == FC_W'(POST_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hold_q <= '0;
      fcnt_q <= '0;
      hs_bit <= 1'b0;
      err    <= 1'b0;
      cfg_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (accept_evt) begin
            cfg_q  <= cfg_in;
            err    <= 1'b0;
            hold_q <= '0;
            state  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (hold_last) begin
            state  <= ST_HSK;
            fcnt_q <= '0;
            hs_bit <= 1'b0;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        ST_HSK: begin
          if (hs_clear_evt) begin
            state  <= ST_TAIL;
            hs_bit <= 1'b1;
            fcnt_q <= '0;
          end else if (timeout_evt) begin
            state <= ST_IDLE;
            err   <= 1'b1;
          end else if (frame_end) begin
            fcnt_q <= fcnt_q + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tail_done_evt)  state  <= ST_DONE;
          else if (frame_end) fcnt_q <= fcnt_q + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  hs_set_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_bit) |-> $past(frame_end));

  // R10
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (state == ST_IDLE && err));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state == ST_HSK || state == ST_TAIL)) |=> (state != ST_HOLD));

endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
  import codec_init_pkg::*;
#(
  parameter int RESET_CYCLES   = 1000000,
  parameter int CLK_DIV        = 16,
  parameter int WORDS          = 4,
  parameter int TIMEOUT_FRAMES = 1024,
  parameter int POST_FRAMES    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  mic_boost_off,
  input  logic                  hpf_on,
  input  logic [2:0]            rate_code,
  input  logic                  stereo_on,
  input  logic [1:0]            fmt_code,
  input  logic                  tri_immediate,
  input  logic                  alt_xtal,
  input  logic [1:0]            frame_code,
  input  logic                  codec_clk_master,
  input  logic                  codec_tx_mute,
  input  logic                  sdin,
  output logic                  codec_rst_n,
  output logic                  data_sel,
  output logic                  link_drive,
  output logic                  sclk_out,
  output logic                  fs_out,
  output logic                  sdout,
  output logic [WORDS*16-1:0]   rx_words,
  output logic                  done,
  output logic                  err
);
  localparam int FRAME_BITS = WORDS * CW_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  codec_cfg_t            cfg_in, cfg_q;
  seq_state_t            state;
  logic                  hs_bit, hs_ret, run;
  logic                  sample, frame_end;
  logic [BIT_W-1:0]      bit_idx;
  logic [FRAME_BITS-1:0] tx_frame;

  assign cfg_in = '{preamp_off: mic_boost_off, hpf_en: hpf_on, rate: rate_code,
                    stereo: stereo_on, fmt: fmt_code, tri_now: tri_immediate,
                    xtal2: alt_xtal, flen: frame_code, cmaster: codec_clk_master,
                    txoff: codec_tx_mute};

  if (WORDS > 2) begin : g_pad
    assign tx_frame = {ctrl_word_a(cfg_q, hs_bit), ctrl_word_b(cfg_q),
                       {(FRAME_BITS - 2*CW_W){1'b0}}};
  end else begin : g_nopad
    assign tx_frame = {ctrl_word_a(cfg_q, hs_bit), ctrl_word_b(cfg_q)};
  end

  codec_init_ctrl #(
    .RESET_CYCLES  (RESET_CYCLES),
    .TIMEOUT_FRAMES(TIMEOUT_FRAMES),
    .POST_FRAMES   (POST_FRAMES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_end(frame_end),
    .hs_ret(hs_ret), .cfg_in(cfg_in), .state(state), .cfg_q(cfg_q),
    .hs_bit(hs_bit), .err(err)
  );

  codec_init_timer #(
    .CLK_DIV   (CLK_DIV),
    .FRAME_BITS(FRAME_BITS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .sclk_o(sclk_out), .fs_o(fs_out),
    .sample_o(sample), .frame_end_o(frame_end), .bit_idx_o(bit_idx)
  );

  codec_init_serdes #(
    .FRAME_BITS(FRAME_BITS),
    .WORDS     (WORDS)
  ) u_serdes (
    .clk(clk), .rst_n(rst_n), .run(run), .sample(sample), .frame_end(frame_end),
    .bit_idx(bit_idx), .tx_frame(tx_frame), .sdin(sdin), .sdout(sdout),
    .hs_ret(hs_ret), .rx_frame(rx_words)
  );

  assign run         = (state == ST_HSK) || (state == ST_TAIL);
  assign link_drive  = run;
  assign codec_rst_n = run || (state == ST_DONE);
  assign data_sel    = (state == ST_DONE);
  assign done        = (state == ST_DONE);

  // R2
  link_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_drive) |-> (codec_rst_n && !data_sel));

  // R7
  sdout_launch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_drive && $past(link_drive) && !$stable(sdout)) |-> !sclk_out);

  // R9
  done_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (data_sel && !link_drive && !sclk_out && !fs_out));

endmodule

// File: tb/tb_codec_init_seq.sv
module tb_codec_init_seq;
  localparam int RST  = 20;
  localparam int DIV  = 16;
  localparam int WDS  = 4;
  localparam int TO   = 6;
  localparam int POST = 4;
  localparam int FB   = WDS * 16;

  logic clk = 0, rst_n = 0, start = 0, sdin = 0;
  logic pre = 0, hpf = 0, st = 0, tri_n = 0, xt = 0, cm = 0, tm = 0;
  logic [2:0] rate = 0;
  logic [1:0] fmt = 0, fl = 0;
  logic codec_rst_n, data_sel, link_drive, sclk_out, fs_out, sdout, done, err;
  logic [FB-1:0] rx_words;

  int checks = 0, errors = 0, ones = 0, fs_rises = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  codec_init_seq #(.RESET_CYCLES(RST), .CLK_DIV(DIV), .WORDS(WDS),
                   .TIMEOUT_FRAMES(TO), .POST_FRAMES(POST)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mic_boost_off(pre), .hpf_on(hpf),
    .rate_code(rate), .stereo_on(st), .fmt_code(fmt), .tri_immediate(tri_n),
    .alt_xtal(xt), .frame_code(fl), .codec_clk_master(cm), .codec_tx_mute(tm),
    .sdin(sdin), .codec_rst_n(codec_rst_n), .data_sel(data_sel),
    .link_drive(link_drive), .sclk_out(sclk_out), .fs_out(fs_out), .sdout(sdout),
    .rx_words(rx_words), .done(done), .err(err));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model state
  int m_mode, m_cnt, m_cyc, m_fr, m_lf;
  logic m_err, m_hs, prev_fs;
  logic [63:0] m_rx;
  int s_pre, s_hpf, s_rate, s_st, s_fmt, s_tri, s_xt, s_fl, s_cm, s_tm;

  function automatic logic txbit(input logic hs, input int b);
    int w;
    if (b / 16 == 0)      w = s_pre*4096 + int'(hs)*1024 + s_hpf*128 + s_rate*8 + s_st*4 + s_fmt;
    else if (b / 16 == 1) w = s_tri*32768 + s_xt*8192 + s_fl*1024 + s_cm*512 + s_tm*256;
    else                  w = 0;
    return ((w >> (15 - (b % 16))) & 1) != 0;
  endfunction

  function automatic logic [63:0] ret_frame(input int lf, input int n1);
    logic [15:0] w0;
    w0 = 16'h8123 + 16'(lf * 257);
    w0[10] = (lf < n1);
    return {w0, 16'hC3E1 ^ 16'(lf), 16'h0F0F, 16'hBEEF - 16'(lf)};
  endfunction

  always @(negedge clk) begin
    logic [63:0] fr;
    logic lk;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_cyc = 0; m_fr = 0; m_lf = 0;
      m_err = 0; m_hs = 0; m_rx = '0; prev_fs = 0;
    end else begin
      case (m_mode)
        0, 4: if (start) begin
          s_pre = int'(pre); s_hpf = int'(hpf); s_rate = int'(rate); s_st = int'(st);
          s_fmt = int'(fmt); s_tri = int'(tri_n); s_xt = int'(xt); s_fl = int'(fl);
          s_cm = int'(cm); s_tm = int'(tm);
          m_err = 0; m_cnt = 0; m_mode = 1;
        end
        1: if (m_cnt == RST - 1) begin
          m_mode = 2; m_cyc = 0; m_fr = 0; m_lf = 0; m_hs = 0;
        end else m_cnt++;
        default: begin
          if (m_cyc == FB * DIV - 1) begin
            fr = ret_frame(m_lf, ones);
            m_rx = fr;
            m_lf++;
            if (m_mode == 2) begin
              if (fr[58] == 1'b0) begin m_mode = 3; m_hs = 1; m_fr = 0; end
              else if (m_fr == TO - 1) begin m_mode = 0; m_err = 1; end
              else m_fr++;
            end else begin
              if (m_fr == POST - 1) m_mode = 4; else m_fr++;
            end
            m_cyc = 0;
          end else m_cyc++;
        end
      endcase
      lk = (m_mode == 2 || m_mode == 3);
      chk("R2 codec_rst_n", 64'(codec_rst_n), 64'(m_mode >= 2));
      chk("R9 data_sel", 64'(data_sel), 64'(m_mode == 4));
      chk("R9 link_drive", 64'(link_drive), 64'(lk));
      chk("R3 sclk_out", 64'(sclk_out), 64'(lk && (m_cyc % DIV) >= DIV / 2));
      chk("R4 fs_out", 64'(fs_out), 64'(lk && m_cyc < DIV));
      if (lk && m_cyc / DIV >= 16)
        chk("R6 sdout", 64'(sdout), 64'(txbit(m_hs, m_cyc / DIV)));
      else
        chk("R5 sdout", 64'(sdout), 64'(lk && txbit(m_hs, m_cyc / DIV)));
      chk("R7 rx_words", rx_words, m_rx);
      chk("R11 done", 64'(done), 64'(m_mode == 4));
      chk("R10 err", 64'(err), 64'(m_err));
      if (fs_out && !prev_fs) fs_rises++;
      prev_fs = fs_out;
    end
    if (m_mode == 2 || m_mode == 3) sdin = ret_frame(m_lf, ones)[63 - m_cyc / DIV];
    else sdin = 1'b0;
  end

  task automatic pulse_start();
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  task automatic wait_end(input int lim);
    int used = 0;
    while (!(done || err) && used < lim) begin @(negedge clk); used++; end
    if (used >= lim) begin
      checks++; errors++;
      $display("FAIL R9 sequence did not end actual=%0d expected<%0d", used, lim);
    end
    @(negedge clk); #1;
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, c;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R1 idle state after reset
    chk("R1 codec_rst_n", 64'(codec_rst_n), 0);
    chk("R1 data_sel", 64'(data_sel), 0);
    chk("R1 link_drive", 64'(link_drive), 0);
    chk("R1 done/err", {62'd0, done, err}, 0);
    chk("R1 rx_words", rx_words, 0);

    // T1: clear after two frames; mid-run start and cfg change ignored
    pre = 1; hpf = 0; rate = 3'b110; st = 1; fmt = 2'b01;
    tri_n = 1; xt = 1; fl = 2'b00; cm = 1; tm = 0; ones = 2;
    base = fs_rises;
    pulse_start();
    repeat (RST + 300) @(negedge clk);
    #1 pre = 0; rate = 3'b001; cm = 0; fmt = 2'b10;
    pulse_start();                 // R11 ignored while running
    wait_end(20000);
    chk("R9 done after tail", 64'(done), 1);
    chk("R8 frames sent", 64'(fs_rises - base), 64'(ones + 1 + POST));

    // T2: codec never clears -> timeout
    hpf = 1; st = 0; fmt = 2'b11; tri_n = 0; xt = 0; fl = 2'b10; tm = 1; ones = 99;
    base = fs_rises;
    pulse_start();
    chk("R11 done cleared by start", 64'(done), 0);
    wait_end(20000);
    chk("R10 err", 64'(err), 1);
    chk("R10 codec_rst_n back low", 64'(codec_rst_n), 0);
    chk("R10 frames before timeout", 64'(fs_rises - base), 64'(TO));

    // T3: first frame clears; check reset hold length
    pre = 1; rate = 3'b111; fl = 2'b01; cm = 1; tm = 0; ones = 0;
    base = fs_rises;
    pulse_start();
    chk("R10 err cleared by start", 64'(err), 0);
    c = 0;
    while (!codec_rst_n && c < 1000) begin @(negedge clk); c++; end
    chk("R2 reset hold cycles", 64'(c), 64'(RST));
    wait_end(20000);
    chk("R8 frames first-clear", 64'(fs_rises - base), 64'(1 + POST));
    chk("R9 data_sel", 64'(data_sel), 1);

    // T4: restart from done, clear after one frame
    ones = 1; hpf = 1; rate = 3'b010;
    base = fs_rises;
    pulse_start();
    chk("R11 done cleared", 64'(done), 0);
    wait_end(20000);
    chk("R8 frames one-retry", 64'(fs_rises - base), 64'(2 + POST));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule